// File: doc/BRIEF.md
# Sampling ADC Conversion and Capture Controller

This block sits on the host side of a 14-bit sampling converter that has a parallel result port. It issues the active-low conversion-start strobe on a fixed sample grid, watches the converter's status line (low while converting, high when idle), and reads the result word once the data lines have settled after the status line rises. Each captured word is sign-extended from 14-bit two's complement to 16 bits and offered on a valid/ready output. The LSB weight is 5 V / 16384.

All timing limits are set in nanoseconds and turned into clock-cycle counts from a clock-period parameter, always rounded up. The strobe stays low for the minimum pulse width and is released well inside the early safe window after the falling edge. The sample period requested by software is clamped to the converter's minimum throughput. A new start also waits a minimum quiet time after the previous conversion ended. A conversion whose status line never rises is abandoned after a timeout. A result that lands while an older word is still unaccepted replaces it and raises an overrun pulse.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `start_n` is 1 and `smp_valid`, `timeout_err` and `overrun_err` are 0.
- R2: Each strobe keeps `start_n` low for exactly LOW_CYC clock cycles (10 at the default 4 ns clock, 40 ns), which is far below the 225 ns early-release limit.
- R3: When conversions finish promptly, successive falling edges of `start_n` are spaced by max(`period_cyc`, MIN_PERIOD_CYC) cycles, where MIN_PERIOD_CYC is 114 by default (454 ns). Shorter requested periods are clamped.
- R4: The result word is sampled SETTLE_CYC cycles (5 by default, 20 ns) after the clock edge that first sees `adc_idle` high following low. Data present before that point is not captured.
- R5: `smp_data` equals the captured 14-bit word with bit 13 copied into bits 15 and 14.
- R6: If `adc_idle` has not risen TIMEOUT_CYC cycles (125 by default, 500 ns) after the strobe falls, `timeout_err` pulses for one cycle, no word is produced, and the controller returns to waiting for the next start.
- R7: A capture while `smp_valid` is 1 and `smp_ready` is 0 raises `overrun_err` for one cycle, and the new word replaces the old one.
- R8: `smp_valid` and `smp_data` hold steady while `smp_ready` is 0, and `smp_valid` drops in the cycle after an accept with no new capture.
- R9: While `run` is 0 no new strobe is issued, and a conversion already started still completes and delivers its word.
- R10: A new strobe falls no earlier than GAP_CYC+1 cycles (26 by default, at least 100 ns) after the edge that detected the end of the previous conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | 1 lets new conversions start |
| period_cyc | input | PERIOD_W | Requested sample period in clock cycles |
| adc_idle | input | 1 | Converter status: 0 while converting, 1 when idle |
| adc_word | input | 14 | Converter result lines, two's complement |
| start_n | output | 1 | Active-low conversion-start strobe |
| smp_valid | output | 1 | Captured word available |
| smp_data | output | 16 | Sign-extended captured word |
| smp_ready | input | 1 | Consumer accepts the word |
| timeout_err | output | 1 | One-cycle pulse on a conversion timeout |
| overrun_err | output | 1 | One-cycle pulse when an unaccepted word is replaced |

## Verification
A behavioural converter model drops the status line when it sees the strobe and raises it after a programmable conversion time. It drives the inverted code until 20 ns after the rise, so a capture taken too early returns a wrong value. The vector table varies the requested period around the clamp value and the conversion length. This separates the three things that can set the start spacing: the requested period, the throughput clamp, and the quiet time after a long conversion. The codes include zero, +1, the most negative value, the most positive value and -1, which exercises sign extension at both ends. Directed runs then hold back the consumer to show that the word is held and then overwritten, leave the status line stuck to force a timeout, and drop `run` while a conversion is in flight.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_WAIT,
        ST_SETTLE
    } cap_state_e;

    function automatic int cycles_ceil(input int time_ps, input int clk_ps);
        return (time_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/adc_cap_sat_cnt.sv
module adc_cap_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (&cnt_q)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/adc_cap_rise.sv
module adc_cap_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b1;
        else
            prev_q <= prev_d;
    end

    assign rise = level && !prev_q;
endmodule

// File: rtl/adc_cap_out.sv
module adc_cap_out #(
    parameter int IN_W  = 14,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [IN_W-1:0]  word,
    input  logic             ready,
    output logic             valid,
    output logic [OUT_W-1:0] data,
    output logic             overrun
);
    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] data;
        logic             ovr;
    } out_reg_t;

    out_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.ovr = 1'b0;
        if (capture) begin
            r_d.valid = 1'b1;
            r_d.data  = {{(OUT_W-IN_W){word[IN_W-1]}}, word};
            r_d.ovr   = r_q.valid && !ready;
        end else if (r_q.valid && ready) begin
            r_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign valid   = r_q.valid;
    assign data    = r_q.data;
    assign overrun = r_q.ovr;
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
    import adc_cap_pkg::*;
#(
    parameter int CLK_PS      = 4000,
    parameter int DATA_W      = 14,
    parameter int OUT_W       = 16,
    parameter int PERIOD_W    = 16,
    parameter int STROBE_PS   = 40000,
    parameter int SETTLE_PS   = 20000,
    parameter int THRU_PS     = 454000,
    parameter int GAP_PS      = 100000,
    parameter int CONV_MAX_PS = 400000,
    parameter int MARGIN_PS   = 100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period_cyc,
    input  logic                adc_idle,
    input  logic [DATA_W-1:0]   adc_word,
    output logic                start_n,
    output logic                smp_valid,
    output logic [OUT_W-1:0]    smp_data,
    input  logic                smp_ready,
    output logic                timeout_err,
    output logic                overrun_err
);
    localparam int LOW_CYC        = cycles_ceil(STROBE_PS, CLK_PS);
    localparam int SETTLE_CYC     = cycles_ceil(SETTLE_PS, CLK_PS);
    localparam int MIN_PERIOD_CYC = cycles_ceil(THRU_PS, CLK_PS);
    localparam int GAP_CYC        = cycles_ceil(GAP_PS, CLK_PS);
    localparam int TIMEOUT_CYC    = cycles_ceil(CONV_MAX_PS + MARGIN_PS, CLK_PS);
    localparam int PH_MAX         = (LOW_CYC > SETTLE_CYC) ? LOW_CYC : SETTLE_CYC;
    localparam int PH_W           = $clog2(PH_MAX + 1);
    localparam int TMO_W          = $clog2(TIMEOUT_CYC + 1);
    localparam int GAP_W          = $clog2(GAP_CYC + 1) + 1;

    typedef struct packed {
        cap_state_e       state;
        logic [PH_W-1:0]  phase;
        logic [TMO_W-1:0] tmo;
        logic             got_rise;
        logic             tmo_err;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic                rise;
    logic                go;
    logic                capture;
    logic                settle_entry;
    logic [PERIOD_W-1:0] eff_period;
    logic [PERIOD_W-1:0] since_start;
    logic [GAP_W-1:0]    since_end;

    adc_cap_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (adc_idle),
        .rise  (rise)
    );

    adc_cap_sat_cnt #(.W(PERIOD_W)) u_since_start (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go),
        .count (since_start)
    );

    adc_cap_sat_cnt #(.W(GAP_W)) u_since_end (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (settle_entry),
        .count (since_end)
    );

    adc_cap_out #(.IN_W(DATA_W), .OUT_W(OUT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .word    (adc_word),
        .ready   (smp_ready),
        .valid   (smp_valid),
        .data    (smp_data),
        .overrun (overrun_err)
    );

    always_comb begin
        eff_period = (period_cyc < PERIOD_W'(MIN_PERIOD_CYC)) ? PERIOD_W'(MIN_PERIOD_CYC) : period_cyc;
        go = (c_q.state == ST_IDLE) && run
             && (since_start >= eff_period - 1'b1)
             && (since_end >= GAP_W'(GAP_CYC));
    end

    always_comb begin
        c_d          = c_q;
        c_d.tmo_err  = 1'b0;
        capture      = 1'b0;
        settle_entry = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (go) begin
                    c_d.state    = ST_STROBE;
                    c_d.phase    = '0;
                    c_d.tmo      = '0;
                    c_d.got_rise = 1'b0;
                end
            end
            ST_STROBE: begin
                c_d.tmo   = c_q.tmo + 1'b1;
                c_d.phase = c_q.phase + 1'b1;
                if (rise)
                    c_d.got_rise = 1'b1;
                if (c_q.phase == PH_W'(LOW_CYC - 1)) begin
                    c_d.phase = '0;
                    if (rise || c_q.got_rise) begin
                        c_d.state    = ST_SETTLE;
                        settle_entry = 1'b1;
                    end else begin
                        c_d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                c_d.tmo = c_q.tmo + 1'b1;
                if (rise) begin
                    c_d.state    = ST_SETTLE;
                    c_d.phase    = '0;
                    settle_entry = 1'b1;
                end else if (c_q.tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
                    c_d.state   = ST_IDLE;
                    c_d.tmo_err = 1'b1;
                end
            end
            ST_SETTLE: begin
                c_d.phase = c_q.phase + 1'b1;
                if (c_q.phase == PH_W'(SETTLE_CYC - 1)) begin
                    capture   = 1'b1;
                    c_d.state = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= '{state: ST_IDLE, phase: '0, tmo: '0, got_rise: 1'b0, tmo_err: 1'b0};
        else
            c_q <= c_d;
    end

    assign start_n     = (c_q.state != ST_STROBE);
    assign timeout_err = c_q.tmo_err;
endmodule

// File: rtl/adc_capture_ctrl_chk.sv
module adc_capture_ctrl_chk #(
    parameter int LOW_CYC        = 10,
    parameter int MIN_PERIOD_CYC = 114,
    parameter int TIMEOUT_CYC    = 125,
    parameter int OUT_W          = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             start_n,
    input logic             smp_valid,
    input logic [OUT_W-1:0] smp_data,
    input logic             smp_ready,
    input logic             timeout_err,
    input logic             overrun_err
);
    logic [15:0] low_cnt;
    logic [15:0] fall_cnt;
    logic        seen_fall;
    logic        sn_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            fall_cnt  <= '1;
            seen_fall <= 1'b0;
            sn_prev   <= 1'b1;
        end else begin
            sn_prev <= start_n;
            low_cnt <= start_n ? 16'd0 : low_cnt + 16'd1;
            if (sn_prev && !start_n) begin
                fall_cnt  <= 16'd1;
                seen_fall <= 1'b1;
            end else if (fall_cnt != 16'hFFFF) begin
                fall_cnt <= fall_cnt + 16'd1;
            end
        end
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sn_prev && start_n) |-> (low_cnt == 16'(LOW_CYC))); // R2

    AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_prev && !start_n && seen_fall) |-> (fall_cnt >= 16'(MIN_PERIOD_CYC))); // R3

    AST_TIMEOUT_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (start_n && fall_cnt == 16'(TIMEOUT_CYC))); // R6

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |-> (smp_valid && $past(smp_valid && !smp_ready))); // R7

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready && !overrun_err) |=> (smp_valid && ($stable(smp_data) || overrun_err))); // R8

    AST_STOPPED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && start_n) |=> start_n); // R9
endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(
    .LOW_CYC        (LOW_CYC),
    .MIN_PERIOD_CYC (MIN_PERIOD_CYC),
    .TIMEOUT_CYC    (TIMEOUT_CYC),
    .OUT_W          (OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .start_n     (start_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .smp_ready   (smp_ready),
    .timeout_err (timeout_err),
    .overrun_err (overrun_err)
);

// File: tb/adc_capture_ctrl_test.sv
module adc_capture_ctrl_test;
    localparam int LOW_E  = 10;
    localparam int MINP_E = 114;
    localparam int GAP_E  = 25;
    localparam int NVEC   = 6;
    // entry: period[47:32], conversion cycles[31:16], 14-bit code[15:0]
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd200, 16'd60,  16'h0001},
        {16'd50,  16'd60,  16'h2000},
        {16'd114, 16'd40,  16'h1FFF},
        {16'd300, 16'd80,  16'h3FFF},
        {16'd113, 16'd30,  16'h0000},
        {16'd115, 16'd100, 16'h2ABC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] period_cyc = 16'd200;
    logic        adc_idle = 1'b1;
    logic [13:0] adc_word = '0;
    logic        start_n;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        smp_ready = 1'b1;
    logic        timeout_err;
    logic        overrun_err;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int cyc = 0, fall_cyc = 0, rise_cyc = 0, last_int = 0, last_low = 0, last_r2f = 0;
    int fall_count = 0, acc_count = 0, tmo_count = 0, ovr_count = 0;
    bit have_fall = 0, prev_sn = 1;
    logic [15:0] last_word = '0;
    int conv = 60, model_cnt = 0, settle_cnt = 0;
    logic [13:0] code = '0;

    always #2 clk = ~clk;

    adc_capture_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .period_cyc  (period_cyc),
        .adc_idle    (adc_idle),
        .adc_word    (adc_word),
        .start_n     (start_n),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .smp_ready   (smp_ready),
        .timeout_err (timeout_err),
        .overrun_err (overrun_err)
    );

    function automatic logic [15:0] sext(input logic [13:0] c);
        return {{2{c[13]}}, c};
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, actual, actual, expected, expected);
        end
    endtask

    // monitor and converter model, both on the falling edge
    always @(negedge clk) begin
        bit fell;
        cyc++;
        fell = prev_sn && !start_n;
        if (fell) begin
            if (have_fall) last_int = cyc - fall_cyc;
            last_r2f  = cyc - rise_cyc;
            fall_cyc  = cyc;
            have_fall = 1;
            fall_count++;
        end
        if (!prev_sn && start_n) last_low = cyc - fall_cyc;
        if (smp_valid && smp_ready) begin
            acc_count++;
            last_word = smp_data;
        end
        if (timeout_err) tmo_count++;
        if (overrun_err) ovr_count++;
        prev_sn = start_n;

        if (model_cnt > 0) begin
            model_cnt--;
            if (model_cnt == 0) begin
                adc_idle   = 1'b1;
                adc_word   = ~code;
                rise_cyc   = cyc;
                settle_cnt = 5;
            end
        end else if (settle_cnt > 0) begin
            settle_cnt--;
            if (settle_cnt == 0) adc_word = code;
        end
        if (fell && conv > 0) begin
            adc_idle  = 1'b0;
            adc_word  = ~code;
            model_cnt = conv;
        end
    end

    task automatic wait_accepts(input int n);
        int target;
        target = acc_count + n;
        while (acc_count < target) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 start_n", start_n, 1);
        check("R1 smp_valid", smp_valid, 0);
        check("R1 timeout_err", timeout_err, 0);
        check("R1 overrun_err", overrun_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 start_n after release", start_n, 1);
        run = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            int p, cv, eff, expi;
            logic [13:0] cd;
            p  = int'(VEC[i][47:32]);
            cv = int'(VEC[i][31:16]);
            cd = VEC[i][13:0];
            period_cyc = VEC[i][47:32];
            conv = cv;
            code = cd;
            wait_accepts(3);
            eff  = (p < MINP_E) ? MINP_E : p;
            expi = (cv + GAP_E + 2 > eff) ? cv + GAP_E + 2 : eff;
            check($sformatf("R3 interval vec%0d", i), last_int, expi);
            check($sformatf("R2 strobe low vec%0d", i), last_low, LOW_E);
            check($sformatf("R4 R5 word vec%0d", i), int'(last_word), int'(sext(cd)));
            if (cv + GAP_E + 2 > eff)
                check($sformatf("R10 end-to-start vec%0d", i), last_r2f, GAP_E + 2);
        end

        // R8 and R7: hold while not ready, then overwrite
        period_cyc = 16'd200;
        conv = 60;
        code = 14'h0123;
        wait_accepts(1);
        begin
            int fc;
            fc = fall_count;
            while (fall_count == fc) @(negedge clk);
        end
        smp_ready = 1'b0;
        while (!smp_valid) @(negedge clk);
        code = 14'h3E00;
        repeat (20) @(negedge clk);
        check("R8 valid held", smp_valid, 1);
        check("R8 data held", int'(smp_data), int'(sext(14'h0123)));
        begin
            int oc;
            oc = ovr_count;
            while (ovr_count == oc) @(negedge clk);
            check("R7 overrun pulse count", ovr_count - oc, 1);
        end
        check("R7 word replaced", int'(smp_data), int'(sext(14'h3E00)));
        check("R7 still valid", smp_valid, 1);
        smp_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 valid dropped after accept", smp_valid, 0);
        check("R8 accepted word", int'(last_word), int'(sext(14'h3E00)));

        // R6: converter never responds
        wait_accepts(1);
        conv = 0;
        begin
            int ac, tc, fc;
            ac = acc_count;
            tc = tmo_count;
            fc = fall_count;
            while (fall_count < fc + 3) @(negedge clk);
            check("R6 timeouts raised", tmo_count - tc, 2);
            check("R6 no word produced", acc_count - ac, 0);
            check("R6 re-arm interval", last_int, 200);
        end

        // R9: stop while a conversion is in flight
        conv = 60;
        code = 14'h0042;
        wait_accepts(1);
        begin
            int fc;
            fc = fall_count;
            while (fall_count == fc) @(negedge clk);
        end
        run = 1'b0;
        wait_accepts(1);
        check("R9 in-flight word delivered", int'(last_word), int'(sext(14'h0042)));
        begin
            int fc;
            fc = fall_count;
            repeat (600) @(negedge clk);
            check("R9 no start while stopped", fall_count - fc, 0);
            check("R9 strobe idle high", start_n, 1);
        end

        finish_run();
    end
endmodule